// File: doc/BRIEF.md
# LCD Palette and Frame Load Sequencer

This block decides what an LCD controller pulls from its DMA source once it has been switched on. It can load a colour lookup table and then stream frame data, load only the lookup table, or stream only frame data. Words arrive 32 bits at a time on a request/valid stream. Each word holds two 16-bit palette halfwords, and the first halfword is a header whose top nibble gives the pixel depth. In frame phases the words are passed on unchanged to the raster side.

Software works through a control word and a status word. The control word holds the run enable, one interrupt enable per status bit, and the load-mode field. The status word collects completion and error events, and each bit has its own rule for being cleared. Clearing the run enable never cuts a frame short: the sequencer finishes the frame it is fetching and only then reports completion. A single interrupt line combines the status bits with their enables.

Top module: `lcdseq_top`

## Requirements
- R1: After reset the control and status words read zero, `dma_req` and `irq` are low, and `depth_code` is 0.
- R2: Control bit 0 is the run enable, bits 7:1 enable the interrupts for status bits 6:0, and bits 21:20 select the load mode. 00 loads the palette and then frames, 01 loads the palette only, and 10 or 11 streams frames only. The field is read back at the same positions.
- R3: Bits 15:12 of the first palette word are the depth code. Code 3 means a 128-word palette, codes 0 to 2 mean 64 words, and codes 4 and above mean 8 words. The last code seen appears on `depth_code`.
- R4: Palette halfword i (low half first) writes LUT entry i with its bits 11:0, laid out as red 11:8, green 7:4, blue 3:0. Entry 0 takes the header halfword without its nibble. Entries beyond the palette length keep their old contents. With READ_REG=1, `lut_color` follows `lut_addr` one cycle later.
- R5: In palette-only mode, requests stop after the last palette word, status bit 6 (palette loaded) is set, and no frame word is presented.
- R6: In a frame phase, each accepted word appears on `px_data` with `px_valid`, and frames of FRAME_WORDS words repeat while the enable stays set.
- R7: When the enable is cleared, fetching goes on to the end of the current frame (or the end of the palette in palette-only mode). Requests then stop and status bit 0 (done) is set.
- R8: Status bit 0 ignores status writes and clears only when the enable is written from 0 to 1.
- R9: Status bit 6 is cleared by writing 1 to it only while the mode field is 01. In any mode it clears when the enable is written from 1 to 0, and enabling leaves it unchanged.
- R10: Status bits 5 (underflow) and 2 (sync lost) are set by their event inputs only while a load is in progress. Status writes do not clear them; they clear when the enable is written from 1 to 0.
- R11: Status bits 1 (vsync), 4 (line) and 3 (bias count) are set by their event inputs and cleared by writing 1 to them.
- R12: `irq` is high exactly when some status bit i is set together with control bit i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| stat_we | input | 1 | Status word write strobe (write 1 to clear) |
| stat_wdata | input | 32 | Status word write data |
| ctrl_q | output | 32 | Control word readback |
| stat_q | output | 32 | Status word readback |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | Word request to the DMA source |
| dma_valid | input | 1 | DMA word valid; a word moves when request and valid are both high |
| dma_data | input | 32 | DMA word |
| px_valid | output | 1 | Frame word valid toward the raster side |
| px_data | output | 32 | Frame word |
| ev_vsync | input | 1 | Vertical sync event pulse |
| ev_line | input | 1 | Line count event pulse |
| ev_acb | input | 1 | Bias-count event pulse |
| ev_underflow | input | 1 | Output FIFO underflow pulse |
| ev_sync_lost | input | 1 | Sync lost pulse |
| depth_code | output | 4 | Depth code from the last palette header |
| lut_addr | input | 8 | Lookup table read index |
| lut_color | output | 12 | Lookup table colour |

## Verification
The bench builds the block with FRAME_WORDS=5 and READ_REG=1. Short frames let a disable that lands in the middle of a frame be followed through to its end, and let a mode-00 run end within a few cycles of its palette. The registered read variant shows the one-cycle lookup latency. Palette headers with codes 3 and 4 reach both the longest and the shortest palette, which shows that a short load leaves higher entries alone.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

   typedef enum logic [1:0] {
      LD_BOTH = 2'b00,
      LD_PAL  = 2'b01,
      LD_FRM  = 2'b10,
      LD_FRMX = 2'b11
   } ld_mode_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_PAL,
      S_FRM,
      S_HOLD
   } seq_st_e;

   // status bit positions
   localparam int ST_DONE  = 0;
   localparam int ST_VSYNC = 1;
   localparam int ST_SYNC  = 2;
   localparam int ST_ACB   = 3;
   localparam int ST_LINE  = 4;
   localparam int ST_FUF   = 5;
   localparam int ST_LPAL  = 6;
   localparam int NST      = 7;

   localparam int PAL_MAX_WORDS = 128;
   localparam int COLOR_W       = 12;

   // palette length in 32-bit words for a header depth code
   function automatic int pal_words(input logic [3:0] code);
      if (code == 4'd3)      return 128;
      else if (code < 4'd3)  return 64;
      else                   return 8;
   endfunction

endpackage

// File: rtl/lcdseq_regs.sv
module lcdseq_regs
   import lcdseq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctrl_we,
   input  logic [31:0] ctrl_wdata,
   input  logic        stat_we,
   input  logic [31:0] stat_wdata,
   input  logic        busy,
   input  logic        done_evt,
   input  logic        lpal_evt,
   input  logic        ev_vsync,
   input  logic        ev_line,
   input  logic        ev_acb,
   input  logic        ev_fuf,
   input  logic        ev_sync,
   output logic        en,
   output logic [1:0]  mode,
   output logic [31:0] ctrl_q,
   output logic [31:0] stat_q,
   output logic        irq
);
   logic [NST-1:0] ie;
   logic [NST-1:0] st_r;
   logic           en_rise, en_fall;
   logic           unused_wd;

   assign unused_wd = ^{ctrl_wdata[31:22], ctrl_wdata[19:8],
                        stat_wdata[31:7], stat_wdata[5], stat_wdata[2:0]};

   assign en_rise = ctrl_we &  ctrl_wdata[0] & ~en;
   assign en_fall = ctrl_we & ~ctrl_wdata[0] &  en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         ie   <= '0;
         mode <= 2'b00;
      end else if (ctrl_we) begin
         en   <= ctrl_wdata[0];
         ie   <= ctrl_wdata[NST:1];
         mode <= ctrl_wdata[21:20];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_r <= '0;
      end else begin
         // completion: cleared only by a fresh enable
         if (en_rise)       st_r[ST_DONE] <= 1'b0;
         else if (done_evt) st_r[ST_DONE] <= 1'b1;
         // write-one-to-clear event bits
         if (ev_vsync)                               st_r[ST_VSYNC] <= 1'b1;
         else if (stat_we && stat_wdata[ST_VSYNC])   st_r[ST_VSYNC] <= 1'b0;
         if (ev_line)                                st_r[ST_LINE]  <= 1'b1;
         else if (stat_we && stat_wdata[ST_LINE])    st_r[ST_LINE]  <= 1'b0;
         if (ev_acb)                                 st_r[ST_ACB]   <= 1'b1;
         else if (stat_we && stat_wdata[ST_ACB])     st_r[ST_ACB]   <= 1'b0;
         // error bits: cleared by disabling
         if (en_fall)               st_r[ST_FUF]  <= 1'b0;
         else if (ev_fuf && busy)   st_r[ST_FUF]  <= 1'b1;
         if (en_fall)               st_r[ST_SYNC] <= 1'b0;
         else if (ev_sync && busy)  st_r[ST_SYNC] <= 1'b1;
         // palette loaded
         if (lpal_evt)
            st_r[ST_LPAL] <= 1'b1;
         else if (en_fall ||
                  (stat_we && stat_wdata[ST_LPAL] && mode == LD_PAL))
            st_r[ST_LPAL] <= 1'b0;
      end
   end

   assign ctrl_q = {10'd0, mode, 12'd0, ie, en};
   assign stat_q = {{(32-NST){1'b0}}, st_r};
   assign irq    = |(st_r & ie);

endmodule

// File: rtl/lcdseq_fetch.sv
module lcdseq_fetch
   import lcdseq_pkg::*;
#(
   parameter int FRAME_WORDS = 320
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic [1:0]  mode,
   input  logic        dma_valid,
   input  logic [31:0] dma_data,
   output logic        dma_req,
   output logic        busy,
   output logic        px_valid,
   output logic [31:0] px_data,
   output logic        done_evt,
   output logic        lpal_evt,
   output logic        wr_en,
   output logic [6:0]  wr_pair,
   output logic [COLOR_W-1:0] wr_lo,
   output logic [COLOR_W-1:0] wr_hi,
   output logic [3:0]  depth_code
);
   localparam int CMAX  = (FRAME_WORDS > PAL_MAX_WORDS) ? FRAME_WORDS : PAL_MAX_WORDS;
   localparam int CNT_W = $clog2(CMAX + 1);
   localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_WORDS - 1);

   seq_st_e          st;
   ld_mode_e         run_mode;
   logic [CNT_W-1:0] cnt, pal_len;
   logic             take, pal_last, frm_last;

   assign dma_req  = (st == S_PAL) || (st == S_FRM);
   assign busy     = (st != S_IDLE);
   assign take     = dma_req & dma_valid;
   assign pal_last = (cnt != '0) && (cnt == pal_len - 1'b1);
   assign frm_last = (cnt == FRM_LAST);

   assign px_valid = (st == S_FRM) & dma_valid;
   assign px_data  = dma_data;

   assign done_evt = ((st == S_FRM) && take && frm_last && !en) ||
                     ((st == S_HOLD) && !en);
   assign lpal_evt = (st == S_PAL) && take && pal_last;

   assign wr_en   = (st == S_PAL) && take;
   assign wr_pair = cnt[6:0];
   assign wr_lo   = dma_data[COLOR_W-1:0];
   assign wr_hi   = dma_data[16+COLOR_W-1:16];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         run_mode   <= LD_BOTH;
         cnt        <= '0;
         pal_len    <= '0;
         depth_code <= 4'd0;
      end else begin
         unique case (st)
            S_IDLE: if (en) begin
               cnt      <= '0;
               run_mode <= ld_mode_e'(mode);
               st       <= (mode == LD_BOTH || mode == LD_PAL) ? S_PAL : S_FRM;
            end
            S_PAL: if (take) begin
               if (cnt == '0) begin
                  depth_code <= dma_data[15:12];
                  pal_len    <= CNT_W'(pal_words(dma_data[15:12]));
               end
               if (pal_last) begin
                  cnt <= '0;
                  st  <= (run_mode == LD_PAL) ? S_HOLD : S_FRM;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_FRM: if (take) begin
               if (frm_last) begin
                  cnt <= '0;
                  if (!en) st <= S_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_HOLD: if (!en) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lcdseq_lut.sv
module lcdseq_lut
   import lcdseq_pkg::*;
#(
   parameter int READ_REG = 1
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [6:0]         wr_pair,
   input  logic [COLOR_W-1:0] wr_lo,
   input  logic [COLOR_W-1:0] wr_hi,
   input  logic [7:0]         rd_addr,
   output logic [COLOR_W-1:0] rd_color
);
   localparam int PAIRS = 128;

   logic [COLOR_W-1:0] bank_ev [PAIRS];
   logic [COLOR_W-1:0] bank_od [PAIRS];
   logic [COLOR_W-1:0] rd_raw;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         bank_ev[wr_pair] <= wr_lo;
         bank_od[wr_pair] <= wr_hi;
      end
   end

   assign rd_raw = rd_addr[0] ? bank_od[rd_addr[7:1]] : bank_ev[rd_addr[7:1]];

   generate
      if (READ_REG != 0) begin : g_rd_reg
         always_ff @(posedge clk) rd_color <= rd_raw;
      end else begin : g_rd_comb
         assign rd_color = rd_raw;
      end
   endgenerate

endmodule

// File: rtl/lcdseq_top.sv
module lcdseq_top
   import lcdseq_pkg::*;
#(
   parameter int FRAME_WORDS = 320,
   parameter int READ_REG    = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctrl_we,
   input  logic [31:0] ctrl_wdata,
   input  logic        stat_we,
   input  logic [31:0] stat_wdata,
   output logic [31:0] ctrl_q,
   output logic [31:0] stat_q,
   output logic        irq,
   output logic        dma_req,
   input  logic        dma_valid,
   input  logic [31:0] dma_data,
   output logic        px_valid,
   output logic [31:0] px_data,
   input  logic        ev_vsync,
   input  logic        ev_line,
   input  logic        ev_acb,
   input  logic        ev_underflow,
   input  logic        ev_sync_lost,
   output logic [3:0]  depth_code,
   input  logic [7:0]  lut_addr,
   output logic [11:0] lut_color
);
   generate
      if (FRAME_WORDS < 2) begin : g_bad_frame
         $error("lcdseq_top: FRAME_WORDS must be at least 2");
      end
      if (READ_REG != 0 && READ_REG != 1) begin : g_bad_rd
         $error("lcdseq_top: READ_REG must be 0 or 1");
      end
   endgenerate

   logic               en, busy, done_evt, lpal_evt, wr_en;
   logic [1:0]         mode;
   logic [6:0]         wr_pair;
   logic [COLOR_W-1:0] wr_lo, wr_hi;

   lcdseq_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .stat_we    (stat_we),
      .stat_wdata (stat_wdata),
      .busy       (busy),
      .done_evt   (done_evt),
      .lpal_evt   (lpal_evt),
      .ev_vsync   (ev_vsync),
      .ev_line    (ev_line),
      .ev_acb     (ev_acb),
      .ev_fuf     (ev_underflow),
      .ev_sync    (ev_sync_lost),
      .en         (en),
      .mode       (mode),
      .ctrl_q     (ctrl_q),
      .stat_q     (stat_q),
      .irq        (irq)
   );

   lcdseq_fetch #(.FRAME_WORDS(FRAME_WORDS)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .mode       (mode),
      .dma_valid  (dma_valid),
      .dma_data   (dma_data),
      .dma_req    (dma_req),
      .busy       (busy),
      .px_valid   (px_valid),
      .px_data    (px_data),
      .done_evt   (done_evt),
      .lpal_evt   (lpal_evt),
      .wr_en      (wr_en),
      .wr_pair    (wr_pair),
      .wr_lo      (wr_lo),
      .wr_hi      (wr_hi),
      .depth_code (depth_code)
   );

   lcdseq_lut #(.READ_REG(READ_REG)) u_lut (
      .clk      (clk),
      .wr_en    (wr_en),
      .wr_pair  (wr_pair),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .rd_addr  (lut_addr),
      .rd_color (lut_color)
   );

endmodule

// File: rtl/lcdseq_chk.sv
module lcdseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ctrl_we,
   input logic       ctrl_wd0,
   input logic [7:0] ctrl_lo,
   input logic [6:0] stat_lo,
   input logic       irq,
   input logic       dma_req
);
   // R8: while done is held the sequencer is idle
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stat_lo[0] |-> !dma_req);

   // R7: done only appears once the enable is already clear
   a_r7_done_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_lo[0]) |-> !ctrl_lo[0]);

   // R12: with every interrupt enable clear the line stays low
   a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_lo[7:1] == 7'd0) |-> !irq);

   // R10: a 1-to-0 enable write wipes the error bits
   a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !ctrl_wd0 && ctrl_lo[0]) |=> (!stat_lo[5] && !stat_lo[2]));

   // R5: palette loaded rises only after a fetch cycle
   a_r5_lpal_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_lo[6]) |-> $past(dma_req));

endmodule

bind lcdseq_top lcdseq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_we  (ctrl_we),
   .ctrl_wd0 (ctrl_wdata[0]),
   .ctrl_lo  (ctrl_q[7:0]),
   .stat_lo  (stat_q[6:0]),
   .irq      (irq),
   .dma_req  (dma_req)
);

// File: tb/lcdseq_top_tb.sv
module lcdseq_top_tb;
   localparam int FW = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic        stat_we = 1'b0;
   logic [31:0] stat_wdata = '0;
   logic [31:0] ctrl_q, stat_q, px_data, dma_data;
   logic        irq, dma_req, px_valid;
   logic        dma_valid = 1'b1;
   logic        ev_vsync = 1'b0, ev_line = 1'b0, ev_acb = 1'b0;
   logic        ev_underflow = 1'b0, ev_sync_lost = 1'b0;
   logic [3:0]  depth_code;
   logic [7:0]  lut_addr = '0;
   logic [11:0] lut_color;

   logic [31:0] src_mem [256];
   int          acc_n = 0;
   int          px_n = 0;
   logic        src_clr = 1'b0;
   int          n_chk = 0;
   int          n_err = 0;

   always #5 clk = ~clk;

   assign dma_data = src_mem[acc_n & 255];

   always @(posedge clk) begin
      if (src_clr) begin
         acc_n <= 0;
         px_n  <= 0;
      end else begin
         if (dma_req && dma_valid) acc_n <= acc_n + 1;
         if (px_valid)             px_n  <= px_n + 1;
      end
   end

   lcdseq_top #(.FRAME_WORDS(FW), .READ_REG(1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .stat_we(stat_we), .stat_wdata(stat_wdata),
      .ctrl_q(ctrl_q), .stat_q(stat_q), .irq(irq),
      .dma_req(dma_req), .dma_valid(dma_valid), .dma_data(dma_data),
      .px_valid(px_valid), .px_data(px_data),
      .ev_vsync(ev_vsync), .ev_line(ev_line), .ev_acb(ev_acb),
      .ev_underflow(ev_underflow), .ev_sync_lost(ev_sync_lost),
      .depth_code(depth_code), .lut_addr(lut_addr), .lut_color(lut_color)
   );

   function automatic logic [11:0] col_a(input int i);
      return 12'(i * 37 + 5);
   endfunction

   function automatic logic [11:0] col_b(input int i);
      return 12'(i * 91 + 291);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [31:0] v);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_we = 1'b0;
   endtask

   task automatic wr_stat(input logic [31:0] v);
      @(negedge clk); stat_we = 1'b1; stat_wdata = v;
      @(negedge clk); stat_we = 1'b0;
   endtask

   task automatic clear_src();
      @(negedge clk); src_clr = 1'b1;
      @(negedge clk); src_clr = 1'b0;
   endtask

   task automatic wait_bit(input int b);
      for (int i = 0; i < 2000 && !stat_q[b]; i++) @(negedge clk);
   endtask

   task automatic read_lut(input logic [7:0] a, output logic [11:0] c);
      @(negedge clk); lut_addr = a;
      @(negedge clk); c = lut_color;
   endtask

   task automatic t_reset();
      check("R1 ctrl", ctrl_q, 32'd0);
      check("R1 stat", stat_q, 32'd0);
      check("R1 req/irq/depth", {26'd0, dma_req, irq, depth_code}, 32'd0);
   endtask

   task automatic t_pal_only();
      logic [11:0] c;
      for (int k = 0; k < 128; k++)
         src_mem[k] = {4'hC, col_a(2*k+1), (k == 0) ? 4'h3 : 4'h5, col_a(2*k)};
      clear_src();
      wr_ctrl(32'h0010_0001);
      check("R2 ctrl readback", ctrl_q, 32'h0010_0001);
      wait_bit(6);
      check("R5 palette words", 32'(acc_n), 32'd128);
      check("R5 req dropped", {31'd0, dma_req}, 32'd0);
      repeat (3) @(negedge clk);
      check("R5 no frame words", {32'(acc_n), 32'(px_n)} >> 0 == 64'd0 ? 32'd1 : 32'(px_n), 32'd0);
      check("R5 no extra fetch", 32'(acc_n), 32'd128);
      check("R3 depth code 3", {28'd0, depth_code}, 32'd3);
      read_lut(8'd0, c);   check("R4 entry 0", {20'd0, c}, {20'd0, col_a(0)});
      read_lut(8'd1, c);   check("R4 entry 1", {20'd0, c}, {20'd0, col_a(1)});
      read_lut(8'd200, c); check("R4 entry 200", {20'd0, c}, {20'd0, col_a(200)});
      read_lut(8'd255, c); check("R4 entry 255", {20'd0, c}, {20'd0, col_a(255)});
      wr_stat(32'h40);
      check("R9 w1c in palette-only", stat_q, 32'd0);
      wr_ctrl(32'h0010_0000);
      repeat (2) @(negedge clk);
      check("R7 done after palette-only stop", stat_q, 32'h1);
   endtask

   task automatic t_frames();
      int bad = 0;
      wr_stat(32'h7F);
      check("R8 done survives status write", stat_q, 32'h1);
      for (int k = 0; k < 256; k++) src_mem[k] = 32'hF000_0000 + 32'(k);
      clear_src();
      wr_ctrl(32'h0020_0001);
      check("R8 done cleared by enable", {31'd0, stat_q[0]}, 32'd0);
      for (int i = 0; i < 500 && acc_n < 12; i++) begin
         @(negedge clk);
         if (px_valid && px_data !== src_mem[acc_n & 255]) bad++;
      end
      wr_ctrl(32'h0020_0000);
      wait_bit(0);
      check("R6 frame data matches", 32'(bad), 32'd0);
      check("R7 current frame completed", 32'(acc_n), 32'd15);
      check("R6 all frame words presented", 32'(px_n), 32'd15);
      repeat (3) @(negedge clk);
      check("R7 idle after done", {31'd0, dma_req}, 32'd0);
      check("R7 no fetch after done", 32'(acc_n), 32'd15);
   endtask

   task automatic t_both();
      logic [11:0] c;
      for (int k = 0; k < 8; k++)
         src_mem[k] = {4'h0, col_b(2*k+1), (k == 0) ? 4'h4 : 4'h9, col_b(2*k)};
      for (int k = 8; k < 16; k++) src_mem[k] = 32'h1234_0000 + 32'(k);
      clear_src();
      wr_ctrl(32'h0000_0001);
      repeat (2) @(negedge clk);
      wr_ctrl(32'h0000_0000);
      wait_bit(0);
      check("R7 palette then one frame", 32'(acc_n), 32'd13);
      check("R2 frame after palette", 32'(px_n), 32'd5);
      check("R3 depth code 4", {28'd0, depth_code}, 32'd4);
      check("R9 loaded kept after late disable", stat_q, 32'h41);
      wr_stat(32'h40);
      check("R9 w1c ignored outside palette-only", stat_q, 32'h41);
      read_lut(8'd15, c); check("R4 short palette entry 15", {20'd0, c}, {20'd0, col_b(15)});
      read_lut(8'd16, c); check("R3 entry 16 untouched", {20'd0, c}, {20'd0, col_a(16)});
   endtask

   task automatic t_events();
      wr_ctrl(32'h0020_00FF);
      check("R2 ie readback", ctrl_q, 32'h0020_00FF);
      check("R9 enable keeps loaded", stat_q, 32'h40);
      @(negedge clk);
      ev_vsync = 1; ev_line = 1; ev_acb = 1; ev_underflow = 1; ev_sync_lost = 1;
      @(negedge clk);
      ev_vsync = 0; ev_line = 0; ev_acb = 0; ev_underflow = 0; ev_sync_lost = 0;
      check("R11 R10 events set", stat_q, 32'h7E);
      check("R12 irq high", {31'd0, irq}, 32'd1);
      wr_stat(32'hFF);
      check("R11 w1c; R10 errors stay", stat_q, 32'h64);
      wr_ctrl(32'h0020_0005);
      check("R12 irq masked", {31'd0, irq}, 32'd0);
      @(negedge clk); ev_vsync = 1;
      @(negedge clk); ev_vsync = 0;
      check("R12 irq from vsync", {31'd0, irq}, 32'd1);
      wr_ctrl(32'h0020_0000);
      check("R10 disable clears errors", stat_q, 32'h02);
      wait_bit(0);
      @(negedge clk); ev_underflow = 1;
      @(negedge clk); ev_underflow = 0;
      check("R10 underflow ignored when idle", stat_q, 32'h03);
   endtask

   task automatic t_mode3();
      wr_stat(32'hFF);
      clear_src();
      wr_ctrl(32'h0030_0001);
      for (int i = 0; i < 100 && acc_n < 3; i++) @(negedge clk);
      check("R2 mode 11 streams frames", 32'(px_n), 32'(acc_n));
      check("R2 mode 11 no palette", {31'd0, stat_q[6]}, 32'd0);
      wr_ctrl(32'h0030_0000);
      wait_bit(0);
      check("R7 mode 11 stops", {31'd0, dma_req}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pal_only();
      t_frames();
      t_both();
      t_events();
      t_mode3();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule